// File: doc/BRIEF.md
# Sleep and Interrupt Wake-Up Controller

This block sequences the power-down and wake-up of a small processor core. The core clock is divided into instruction cycles of four phases, and a phase counter output (`q_phase`, values 0 to 3) marks them. A sleep or watchdog-clear request from the core is accepted only on the last phase of an instruction cycle. The controller decides whether a sleep request really halts the core, and it tracks two active-low status bits: `to_n` (time-out) and `pd_n` (power-down). It also pulses the watchdog clear. When an interrupt wakes the core, the controller sends it to the interrupt vector or lets it continue in line.

An interrupt source is pending when its flag and its enable are both set. A sleep request that finds an interrupt already pending is turned into a no-op, so software can read `pd_n` to learn whether the core slept. While the core sleeps, a pending interrupt wakes it whatever the global enable says. In the three crystal oscillator modes, wake-up first waits for a start-up count. In the no-wait mode (RC or external clock), wake-up is immediate. The global enable then decides what follows: with it set, the core runs one dummy instruction cycle and then takes the vector; with it clear, the core resumes at the next instruction.

The controller has four states. RUN is the normal running state. SLEEP is the halted state that waits for an interrupt. OST is the halted state in which the start-up counter runs. DUMMY is the single instruction cycle that comes before the vector jump. The transitions are:
- accept_sleep: RUN to SLEEP, on the last phase with no interrupt pending.
- wake_wait: SLEEP to OST, when an interrupt is pending and a crystal mode is selected.
- wake_direct: SLEEP to RUN or DUMMY, in the no-wait mode.
- count_done: OST to RUN or DUMMY, when the counter reaches zero.
- dummy_done: DUMMY to RUN, on the last phase of the dummy cycle.

Top module: `sleepwake_ctrl`

## Requirements
- R1: An interrupt source is pending only when `irq_flag[i]` and `irq_en[i]` are both 1. A flag whose enable is 0 neither blocks a sleep request nor wakes the core.
- R2: If a sleep request is seen on phase 3 while an interrupt is pending, nothing happens. `wdt_clr` stays 0, `to_n` and `pd_n` keep their values, and `core_halt` stays 0.
- R3: If a sleep request is seen on phase 3 with no interrupt pending, the next cycle shows `wdt_clr`=1 for one cycle, `to_n`=1, `pd_n`=0 and `core_halt`=1. `pd_n` stays 0 for as long as `core_halt` is 1.
- R4: With `osc_mode`=2'b11 (no wait), a pending interrupt during SLEEP drops `core_halt` on the next cycle.
- R5: With `osc_mode` set to 2'b00, 2'b01 or 2'b10 (crystal modes), a pending interrupt during SLEEP loads `ost_count` with OST_LEN-1. The count then falls by one each cycle while `core_halt` stays 1. `core_halt` drops on the cycle after the count has shown 0. `ost_count` reads 0 whenever the counter is not running.
- R6: Changes of the flags or enables while the start-up count runs neither restart it nor stop it.
- R7: A wake-up with `gie`=1 enters DUMMY for exactly four cycles (`q_phase` 0 to 3). `vector_jump` then pulses for one cycle. A sleep request during DUMMY is ignored.
- R8: A wake-up with `gie`=0 pulses `resume_inline` for one cycle on the cycle `core_halt` drops, and `vector_jump` stays 0.
- R9: `q_phase` counts 0,1,2,3 and wraps while the core runs. It holds 0 while `core_halt` is 1.
- R10: A watchdog-clear request seen on phase 3 without a sleep request gives `wdt_clr`=1 for one cycle, `to_n`=1 and `pd_n`=1.
- R11: After reset the state is RUN: `core_halt`=0, `to_n`=1, `pd_n`=1, `ost_count`=0, `q_phase`=0, and every pulse output is 0.
- R12: If a sleep request and a watchdog-clear request arrive on the same phase 3, the sleep request takes priority.
- R13: A `wdt_timeout` pulse drives `to_n` to 0 unless a clear or an accepted sleep sets it in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, one tick per phase |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_req | input | 1 | Core is executing a sleep instruction |
| clrwdt_req | input | 1 | Core is executing a watchdog clear |
| wdt_timeout | input | 1 | Watchdog counter expired |
| irq_flag | input | N_SRC | Interrupt flag bits |
| irq_en | input | N_SRC | Interrupt enable bits |
| gie | input | 1 | Global interrupt enable |
| osc_mode | input | 2 | 00/01/10 crystal modes, 11 no start-up wait |
| wdt_clr | output | 1 | One-cycle clear of watchdog and postscaler |
| to_n | output | 1 | Time-out status bit, active low |
| pd_n | output | 1 | Power-down status bit, active low |
| core_halt | output | 1 | Core halted, program counter held |
| ost_count | output | CNT_W | Oscillator start-up counter |
| q_phase | output | 2 | Current phase within the instruction cycle |
| vector_jump | output | 1 | One-cycle redirect to the interrupt vector |
| resume_inline | output | 1 | One-cycle resume at the next instruction |

## Verification
The assertions check the following on every cycle:
- `pd_n` is low whenever the core is halted.
- The start-up count falls strictly by one and never restarts while it is non-zero.
- The phase is frozen while halted.
- The pulse outputs never overlap.
- A vector jump only follows the dummy cycle.
- A sleep request made with an interrupt pending leaves the status bits and the halt alone.

Other behaviours show up only in the bench's scenarios, where a cycle-level reference model compares every output on every clock:
- the distinction between a flag with and without its enable;
- the choice between the vector and in-line resumption;
- the full length of the start-up wait in a crystal mode against its absence in the no-wait mode;
- the priority of a sleep request over a same-cycle clear.

// File: rtl/sleepwake_pkg.sv
package sleepwake_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_OST   = 2'd2,
        ST_DUMMY = 2'd3
    } sw_state_t;

    // oscillator select value that needs no start-up wait
    localparam logic [1:0] OSC_NOWAIT = 2'b11;

    localparam int unsigned PHASES = 4;

endpackage

// File: rtl/sw_phase_gen.sv
module sw_phase_gen #(
    parameter int unsigned NPH = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   freeze,
    output logic [$clog2(NPH)-1:0] phase,
    output logic                   last
);
    localparam int unsigned PW = $clog2(NPH);
    localparam logic [PW-1:0] LAST_PH = PW'(NPH - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (!freeze) begin
            phase <= (phase == LAST_PH) ? '0 : phase + 1'b1;
        end
    end

    assign last = (phase == LAST_PH);
endmodule

// File: rtl/sw_pend_detect.sv
module sw_pend_detect #(
    parameter int unsigned N_SRC = 4
) (
    input  logic [N_SRC-1:0] flag,
    input  logic [N_SRC-1:0] en,
    output logic             any_pend
);
    logic [N_SRC-1:0] src_pend;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign src_pend[i] = flag[i] & en[i];
    end

    assign any_pend = |src_pend;
endmodule

// File: rtl/sw_ost_counter.sv
module sw_ost_counter #(
    parameter int unsigned LEN = 1024,
    parameter int unsigned W   = $clog2(LEN)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         run,
    output logic [W-1:0] count,
    output logic         zero
);
    localparam logic [W-1:0] START = W'(LEN - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= START;
        end else if (run && count != '0) begin
            count <= count - 1'b1;
        end
    end

    assign zero = (count == '0);
endmodule

// File: rtl/sleepwake_ctrl.sv
module sleepwake_ctrl
    import sleepwake_pkg::*;
#(
    parameter int unsigned N_SRC   = 4,
    parameter int unsigned OST_LEN = 1024,
    parameter int unsigned CNT_W   = $clog2(OST_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_req,
    input  logic             clrwdt_req,
    input  logic             wdt_timeout,
    input  logic [N_SRC-1:0] irq_flag,
    input  logic [N_SRC-1:0] irq_en,
    input  logic             gie,
    input  logic [1:0]       osc_mode,
    output logic             wdt_clr,
    output logic             to_n,
    output logic             pd_n,
    output logic             core_halt,
    output logic [CNT_W-1:0] ost_count,
    output logic [1:0]       q_phase,
    output logic             vector_jump,
    output logic             resume_inline
);
    sw_state_t state_q, state_d;
    logic      pend, q_last, ost_zero;
    logic      accept_sleep, accept_clr, crystal;
    logic      wake_direct, wake_wait, count_done, wake, dummy_done;

    sw_phase_gen #(.NPH(PHASES)) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .freeze (core_halt),
        .phase  (q_phase),
        .last   (q_last)
    );

    sw_pend_detect #(.N_SRC(N_SRC)) u_pend (
        .flag     (irq_flag),
        .en       (irq_en),
        .any_pend (pend)
    );

    sw_ost_counter #(.LEN(OST_LEN), .W(CNT_W)) u_ost (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (wake_wait),
        .run   (state_q == ST_OST),
        .count (ost_count),
        .zero  (ost_zero)
    );

    // transition conditions
    always_comb begin
        crystal      = (osc_mode != OSC_NOWAIT);
        accept_sleep = (state_q == ST_RUN) && q_last && sleep_req && !pend;
        accept_clr   = (state_q == ST_RUN) && q_last && !sleep_req && clrwdt_req;
        wake_wait    = (state_q == ST_SLEEP) && pend && crystal;
        wake_direct  = (state_q == ST_SLEEP) && pend && !crystal;
        count_done   = (state_q == ST_OST) && ost_zero;
        wake         = wake_direct || count_done;
        dummy_done   = (state_q == ST_DUMMY) && q_last;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (accept_sleep) state_d = ST_SLEEP;
            ST_SLEEP: begin
                if (wake_wait)        state_d = ST_OST;
                else if (wake_direct) state_d = gie ? ST_DUMMY : ST_RUN;
            end
            ST_OST:   if (count_done) state_d = gie ? ST_DUMMY : ST_RUN;
            ST_DUMMY: if (dummy_done) state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wdt_clr       <= 1'b0;
            to_n          <= 1'b1;
            pd_n          <= 1'b1;
            vector_jump   <= 1'b0;
            resume_inline <= 1'b0;
        end else begin
            wdt_clr       <= accept_sleep || accept_clr;
            vector_jump   <= dummy_done;
            resume_inline <= wake && !gie;
            if (accept_sleep || accept_clr) to_n <= 1'b1;
            else if (wdt_timeout)           to_n <= 1'b0;
            if (accept_sleep)    pd_n <= 1'b0;
            else if (accept_clr) pd_n <= 1'b1;
        end
    end

    assign core_halt = (state_q == ST_SLEEP) || (state_q == ST_OST);
endmodule

// File: rtl/sleepwake_chk.sv
module sleepwake_chk
    import sleepwake_pkg::*;
#(
    parameter int unsigned N_SRC = 4,
    parameter int unsigned CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sleep_req,
    input logic             wdt_timeout,
    input logic [N_SRC-1:0] irq_flag,
    input logic [N_SRC-1:0] irq_en,
    input logic             wdt_clr,
    input logic             to_n,
    input logic             pd_n,
    input logic             core_halt,
    input logic [CNT_W-1:0] ost_count,
    input logic [1:0]       q_phase,
    input logic             vector_jump,
    input logic             resume_inline,
    input sw_state_t        state_q
);
    logic chk_pend;
    assign chk_pend = |(irq_flag & irq_en);

    assert_halt_pd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        core_halt |-> !pd_n);

    assert_noop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && q_phase == 2'd3 && sleep_req && chk_pend && !wdt_timeout)
        |=> (!wdt_clr && !core_halt && $stable(pd_n) && $stable(to_n)));

    assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ost_count != '0) |=> (ost_count == $past(ost_count) - 1'b1));

    assert_count_halt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ost_count != '0) |-> core_halt);

    assert_phase_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        core_halt |-> (q_phase == 2'd0));

    assert_pulse_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({vector_jump, resume_inline, wdt_clr}));

    assert_vec_after_dummy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vector_jump |-> $past(state_q == ST_DUMMY));

    assert_clr_to_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clr |-> to_n);
endmodule

bind sleepwake_ctrl sleepwake_chk #(.N_SRC(N_SRC), .CNT_W(CNT_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .sleep_req     (sleep_req),
    .wdt_timeout   (wdt_timeout),
    .irq_flag      (irq_flag),
    .irq_en        (irq_en),
    .wdt_clr       (wdt_clr),
    .to_n          (to_n),
    .pd_n          (pd_n),
    .core_halt     (core_halt),
    .ost_count     (ost_count),
    .q_phase       (q_phase),
    .vector_jump   (vector_jump),
    .resume_inline (resume_inline),
    .state_q       (state_q)
);

// File: tb/sleepwake_ctrl_tb_top.sv
module sleepwake_ctrl_tb_top;
    localparam int N_SRC   = 4;
    localparam int OST_LEN = 1024;
    localparam int CW      = $clog2(OST_LEN);
    localparam int VW      = 8 + CW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_req = 0, clrwdt_req = 0, wdt_timeout = 0, gie = 0;
    logic [N_SRC-1:0] irq_flag = '0, irq_en = '0;
    logic [1:0] osc_mode = 2'b11;
    logic wdt_clr, to_n, pd_n, core_halt, vector_jump, resume_inline;
    logic [CW-1:0] ost_count;
    logic [1:0] q_phase;

    int errors = 0, checks = 0, cycles = 0;
    string cur_req = "R11";
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    sleepwake_ctrl #(.N_SRC(N_SRC), .OST_LEN(OST_LEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .clrwdt_req(clrwdt_req),
        .wdt_timeout(wdt_timeout), .irq_flag(irq_flag), .irq_en(irq_en), .gie(gie),
        .osc_mode(osc_mode), .wdt_clr(wdt_clr), .to_n(to_n), .pd_n(pd_n),
        .core_halt(core_halt), .ost_count(ost_count), .q_phase(q_phase),
        .vector_jump(vector_jump), .resume_inline(resume_inline)
    );

    // behavioural reference: mode 0 running, 1 halted waiting, 2 counting, 3 dummy cycle
    int  m_mode, m_q, m_cnt;
    bit  m_wdt, m_to, m_pd, m_vec, m_inl;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode <= 0; m_q <= 0; m_cnt <= 0;
            m_wdt <= 0; m_to <= 1; m_pd <= 1; m_vec <= 0; m_inl <= 0;
        end else begin
            bit p, do_wake, took;
            p = ((irq_flag & irq_en) != 0);
            do_wake = 0; took = 0;
            m_wdt <= 0; m_vec <= 0; m_inl <= 0;
            if (m_mode == 0 || m_mode == 3) m_q <= (m_q + 1) % 4;
            if (m_mode == 0 && m_q == 3) begin
                if (sleep_req && !p) begin
                    m_mode <= 1; m_wdt <= 1; m_pd <= 0; took = 1;
                end else if (!sleep_req && clrwdt_req) begin
                    m_wdt <= 1; m_pd <= 1; took = 1;
                end
            end else if (m_mode == 1 && p) begin
                if (osc_mode != 2'b11) begin m_mode <= 2; m_cnt <= OST_LEN - 1; end
                else do_wake = 1;
            end else if (m_mode == 2) begin
                if (m_cnt == 0) do_wake = 1;
                else m_cnt <= m_cnt - 1;
            end else if (m_mode == 3 && m_q == 3) begin
                m_mode <= 0; m_vec <= 1;
            end
            if (do_wake) begin
                if (gie) m_mode <= 3;
                else begin m_mode <= 0; m_inl <= 1; end
            end
            if (took) m_to <= 1;
            else if (wdt_timeout) m_to <= 0;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // compare every output against the model on each falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [VW-1:0] a, e;
            a = {wdt_clr, to_n, pd_n, core_halt, vector_jump, resume_inline, q_phase, ost_count};
            e = {m_wdt, m_to, m_pd, (m_mode == 1 || m_mode == 2), m_vec, m_inl,
                 2'(m_q), CW'(m_cnt)};
            checks++;
            if (a !== e) begin
                errors++;
                $display("FAIL %s cycle=%0d actual=%h expected=%h", cur_req, cycles, a, e);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // hold the request(s) until the phase-3 edge has taken them
    task automatic issue(input bit s, input bit c);
        sleep_req = s; clrwdt_req = c;
        while (q_phase != 2'd3) @(negedge clk);
        @(negedge clk);
        sleep_req = 0; clrwdt_req = 0;
    endtask

    task automatic wait_run();
        int n = 0;
        while (core_halt && n < 5000) begin @(negedge clk); n++; end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        check("R11", {core_halt, to_n, pd_n}, 3'b011);
        check("R11", ost_count, 0);

        // R9 phase rotation
        cur_req = "R9";
        for (int i = 0; i < 8; i++) begin
            check("R9", q_phase, (i + 1) % 4);
            @(negedge clk);
        end

        // R13 timeout then R10 clear
        cur_req = "R13";
        wdt_timeout = 1; @(negedge clk); wdt_timeout = 0;
        check("R13", to_n, 0);
        cur_req = "R10";
        issue(0, 1);
        check("R10", {wdt_clr, to_n, pd_n}, 3'b111);

        // R2 sleep with enabled pending source is a no-op
        cur_req = "R2";
        wdt_timeout = 1; @(negedge clk); wdt_timeout = 0;
        irq_flag = 4'b0100; irq_en = 4'b0100;
        issue(1, 0);
        check("R2", {wdt_clr, core_halt, to_n, pd_n}, 4'b0001);

        // R1 flag without enable does not block; R3 sleep entry
        cur_req = "R1";
        irq_en = 4'b0010;
        issue(1, 0);
        check("R3", {wdt_clr, core_halt, to_n, pd_n}, 4'b1110);
        repeat (5) @(negedge clk);
        check("R1", core_halt, 1);

        // R4 / R8 direct wake with gie clear
        cur_req = "R8";
        osc_mode = 2'b11; gie = 0;
        irq_flag = 4'b0010;
        @(negedge clk);
        check("R4", core_halt, 0);
        check("R8", {resume_inline, vector_jump}, 2'b10);
        irq_flag = '0; irq_en = '0;
        repeat (3) @(negedge clk);

        // R5 / R6 / R7 crystal wake with gie set
        cur_req = "R5";
        issue(1, 0);
        osc_mode = 2'b01; gie = 1;
        @(negedge clk);
        irq_flag = 4'b0001; irq_en = 4'b0001;
        @(negedge clk);
        check("R5", ost_count, OST_LEN - 1);
        cur_req = "R6";
        irq_flag = 4'b1001; irq_en = 4'b1000;
        repeat (200) @(negedge clk);
        irq_flag = 4'b0000;
        repeat (300) @(negedge clk);
        check("R6", ost_count, OST_LEN - 1 - 500);
        cur_req = "R5";
        wait_run();
        check("R5", core_halt, 0);
        cur_req = "R7";
        sleep_req = 1;
        for (int i = 0; i < 4; i++) begin
            check("R7", vector_jump, 0);
            @(negedge clk);
        end
        check("R7", vector_jump, 1);
        sleep_req = 0;
        irq_en = '0;
        repeat (3) @(negedge clk);

        // R12 sleep wins over clear, then crystal wake with gie clear
        cur_req = "R12";
        issue(1, 1);
        check("R12", {core_halt, pd_n}, 2'b10);
        osc_mode = 2'b10; gie = 0;
        irq_flag = 4'b1000; irq_en = 4'b1000;
        @(negedge clk);
        cur_req = "R8";
        wait_run();
        check("R8", resume_inline, 1);
        irq_flag = '0; irq_en = '0;
        repeat (6) @(negedge clk);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule